// File: doc/BRIEF.md
# Pipelined Coefficient Barrel Rotator

This block turns a packed vector of N coefficients, each CW bits wide, cyclically by a run-time amount. Coefficient j of the result is coefficient (j − amount) mod N of the input, so coefficients move toward higher indices and the top ones wrap around to index 0. This is the rotate step of a sparse polynomial multiplier in the ring of polynomials modulo X^N − 1. There, each nonzero position of a ternary operand selects one rotated copy of the dense operand, which the caller then adds to or subtracts from an accumulator.

The rotator is a logarithmic cascade. Stage k moves the vector by 2^k mod N coefficients when bit k of the amount is set, and passes it unchanged otherwise. A compile-time mask places a pipeline register after any subset of the stages. The unused high bits of the amount ride in the same registers as the data, so each stage sees the amount that entered with its own vector. A valid flag travels beside them. The mask changes latency and clock rate only. The result is the same for every mask.

Top module: `coef_barrel_rotator`

## Requirements
- R1: For every amount from 0 to N−1, output coefficient j (bits j·CW upward) equals input coefficient (j − amount) mod N.
- R2: An amount of N or above, up to 2^AW − 1, gives the same result as a rotation by amount mod N.
- R3: out_vld rises exactly L clock cycles after the in_vld cycle that carried the item, where L is the number of set bits in REG_MASK (4 with the default mask, where bits 0, 3, 6 and 8 are set).
- R4: Each accepted item (in_vld high at a rising edge) yields exactly one out_vld cycle, and out_vld stays low when no item is in flight; idle gaps in the input produce no output.
- R5: While rst_n is low, and after its release until the first item has passed through, out_vld is low.
- R6: Items accepted on consecutive cycles each come out with the rotation given by their own amount, in their order of arrival.
- R7: An amount of 0 returns the input vector unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_vld | input | 1 | Input item present this cycle |
| in_amt | input | AW (9) | Rotation amount in coefficients |
| in_vec | input | N·CW (4873) | Packed coefficients, coefficient 0 in the low bits |
| out_vld | output | 1 | Rotated item present this cycle |
| out_vec | output | N·CW (4873) | Rotated packed coefficients |

## Verification
On every cycle, the assertions check the valid flag and the forwarded payload of each inserted register, so that a flag never drops, never appears from nothing, and never loses its payload. They also check that the count of items in flight never exceeds the pipeline depth and never goes negative. They cannot show that the rotation itself is correct. Only the bench scenarios can show that the coefficients land where the modulo-N rule puts them, for non-power-of-two amounts, for amounts at or above N, for back-to-back streams with mixed amounts, and with exactly the expected latency.

// File: rtl/coef_rot_pkg.sv
package coef_rot_pkg;

   // Distance moved by stage k, reduced modulo the ring size n.
   function automatic int unsigned rot_step(input int unsigned k, input int unsigned n);
      int unsigned p;
      p = 1 % n;
      for (int unsigned i = 0; i < k; i++) begin
         p = (p * 2) % n;
      end
      return p;
   endfunction

endpackage

// File: rtl/coef_rot_shift.sv
module coef_rot_shift #(
   parameter int unsigned N    = 443,
   parameter int unsigned CW   = 11,
   parameter int unsigned STEP = 1
) (
   input  logic            sel,
   input  logic [N*CW-1:0] d_i,
   output logic [N*CW-1:0] d_o
);
   localparam int unsigned VW = N * CW;
   localparam int unsigned SB = STEP * CW;

   generate
      if (STEP == 0) begin : g_none
         logic unused_sel;
         assign unused_sel = sel;
         assign d_o = d_i;
      end else begin : g_turn
         logic [VW-1:0] turned;
         // top STEP coefficients wrap down to index 0
         assign turned = {d_i[VW-SB-1:0], d_i[VW-1:VW-SB]};
         assign d_o    = sel ? turned : d_i;
      end
   endgenerate
endmodule

// File: rtl/coef_rot_reg.sv
module coef_rot_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_i,
   input  logic [W-1:0] pay_i,
   output logic         vld_o,
   output logic [W-1:0] pay_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= vld_i;
   end

   // payload only loads with a live item; no reset needed
   always_ff @(posedge clk) begin
      if (vld_i) pay_o <= pay_i;
   end

   // R4: a live flag is carried one cycle on
   a_r4_vld_carry: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> vld_o);
   // R4: no flag appears without an input flag
   a_r4_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> !vld_o);
   // R6: remaining amount bits and data travel with their flag
   a_r6_payload_kept: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> (pay_o == $past(pay_i)));
endmodule

// File: rtl/coef_barrel_rotator.sv
module coef_barrel_rotator
   import coef_rot_pkg::*;
#(
   parameter int unsigned     N        = 443,
   parameter int unsigned     CW       = 11,
   parameter int unsigned     AW       = 9,
   parameter logic [AW-1:0]   REG_MASK = 9'h149
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [AW-1:0]   in_amt,
   input  logic [N*CW-1:0] in_vec,
   output logic            out_vld,
   output logic [N*CW-1:0] out_vec
);
   localparam int unsigned VW  = N * CW;
   localparam int unsigned LAT = $countones(REG_MASK);

   // elaboration-time parameter checks
   generate
      if (N < 2) begin : g_bad_n
         $error("coef_barrel_rotator: N must be at least 2");
      end
      if (CW < 1) begin : g_bad_cw
         $error("coef_barrel_rotator: CW must be at least 1");
      end
      if (AW < 1 || AW > 30) begin : g_bad_aw
         $error("coef_barrel_rotator: AW out of range");
      end
      if ((64'd1 << AW) < 64'(N)) begin : g_short_aw
         $error("coef_barrel_rotator: AW too narrow to reach N-1");
      end
   endgenerate

   generate
      for (genvar k = 0; k < AW; k++) begin : g_st
         logic [AW-1-k:0] amt_here;
         logic [VW-1:0]   d_here;
         logic [VW-1:0]   d_rot;
         logic            v_here;
         logic [VW-1:0]   d_next;
         logic            v_next;

         if (k == 0) begin : g_src
            assign amt_here = in_amt;
            assign d_here   = in_vec;
            assign v_here   = in_vld;
         end else begin : g_link
            assign amt_here = g_st[k-1].g_fwd.amt_next;
            assign d_here   = g_st[k-1].d_next;
            assign v_here   = g_st[k-1].v_next;
         end

         coef_rot_shift #(
            .N   (N),
            .CW  (CW),
            .STEP(rot_step(k, N))
         ) u_shift (
            .sel(amt_here[0]),
            .d_i(d_here),
            .d_o(d_rot)
         );

         if (k < AW - 1) begin : g_fwd
            logic [AW-2-k:0] amt_next;
            if (REG_MASK[k]) begin : g_reg
               logic [VW+AW-2-k:0] pay_q;
               coef_rot_reg #(.W(VW + AW - 1 - k)) u_reg (
                  .clk  (clk),
                  .rst_n(rst_n),
                  .vld_i(v_here),
                  .pay_i({amt_here[AW-1-k:1], d_rot}),
                  .vld_o(v_next),
                  .pay_o(pay_q)
               );
               assign amt_next = pay_q[VW+AW-2-k:VW];
               assign d_next   = pay_q[VW-1:0];
            end else begin : g_thru
               assign amt_next = amt_here[AW-1-k:1];
               assign d_next   = d_rot;
               assign v_next   = v_here;
            end
         end else begin : g_last
            if (REG_MASK[k]) begin : g_reg
               coef_rot_reg #(.W(VW)) u_reg (
                  .clk  (clk),
                  .rst_n(rst_n),
                  .vld_i(v_here),
                  .pay_i(d_rot),
                  .vld_o(v_next),
                  .pay_o(d_next)
               );
            end else begin : g_thru
               assign d_next = d_rot;
               assign v_next = v_here;
            end
         end
      end
   endgenerate

   assign out_vec = g_st[AW-1].d_next;
   assign out_vld = g_st[AW-1].v_next;

   // in-flight bound: items inside never exceed the register count
   generate
      if (LAT > 0) begin : g_flight
         localparam int unsigned FW = $clog2(LAT + 2);
         logic [FW-1:0] inflight;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) inflight <= '0;
            else        inflight <= inflight + FW'(in_vld) - FW'(out_vld);
         end
         // R3: never more items inside than register positions
         a_r3_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
            inflight <= FW'(LAT));
         // R4: an output needs an item that entered earlier
         a_r4_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |-> (inflight != '0));
      end
   endgenerate
endmodule

// File: tb/coef_barrel_rotator_bench.sv
`timescale 1ns/1ps
module coef_barrel_rotator_bench;
   localparam int N   = 443;
   localparam int CW  = 11;
   localparam int AW  = 9;
   localparam int VW  = N * CW;
   localparam int LAT = 4;   // bits 0,3,6,8 of the default mask

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic [AW-1:0] in_amt = '0;
   logic [VW-1:0] in_vec = '0;
   logic          out_vld;
   logic [VW-1:0] out_vec;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   logic [VW-1:0] exp_q[$];
   int            stamp_q[$];
   string         tag_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   coef_barrel_rotator u_coef_barrel_rotator (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_vld (in_vld),
      .in_amt (in_amt),
      .in_vec (in_vec),
      .out_vld(out_vld),
      .out_vec(out_vec)
   );

   function automatic logic [VW-1:0] make_vec(input int seed);
      logic [VW-1:0] v;
      for (int j = 0; j < N; j++)
         v[j*CW +: CW] = CW'((j * 37 + seed * 101 + 5) % (1 << CW));
      return v;
   endfunction

   function automatic logic [VW-1:0] ref_rot(input logic [VW-1:0] v, input int s);
      logic [VW-1:0] r;
      for (int j = 0; j < N; j++)
         r[j*CW +: CW] = v[((j + N - s) % N)*CW +: CW];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic push_item(input int amt, input int seed, input string tag);
      logic [VW-1:0] v;
      @(negedge clk);
      v = make_vec(seed);
      in_vec = v;
      in_amt = AW'(amt);
      in_vld = 1'b1;
      exp_q.push_back(ref_rot(v, amt % N));
      stamp_q.push_back(cyc);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_vld) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", "unexpected output item", 1, 0);
            end else begin
               logic [VW-1:0] e;
               int st, bad;
               string tg;
               e  = exp_q.pop_front();
               st = stamp_q.pop_front();
               tg = tag_q.pop_front();
               bad = -1;
               for (int j = N - 1; j >= 0; j--)
                  if (out_vec[j*CW +: CW] !== e[j*CW +: CW]) bad = j;
               if (bad < 0)
                  check(1'b1, tg, "data", 0, 0);
               else
                  check(1'b0, tg, $sformatf("coef %0d", bad),
                        int'(out_vec[bad*CW +: CW]), int'(e[bad*CW +: CW]));
               check((cyc - st) == LAT, "R3", "latency", cyc - st, LAT);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "R4", "watchdog expired", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R5: reset state
      repeat (3) @(negedge clk);
      check(out_vld === 1'b0, "R5", "out_vld during reset", int'(out_vld), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(out_vld === 1'b0, "R5", "out_vld after reset, idle", int'(out_vld), 0);

      // R7: zero amount
      push_item(0, 1, "R7");
      idle(8);
      // R1: powers of two, one by one
      for (int k = 0; k < AW; k++) begin
         push_item(1 << k, 10 + k, "R1");
         idle(2);
      end
      // R1: composite amounts and the top of the range
      push_item(3, 30, "R1");
      push_item(77, 31, "R1");
      push_item(300, 32, "R1");
      push_item(441, 33, "R1");
      push_item(N - 1, 34, "R1");
      idle(6);
      // R2: amounts at or above N
      push_item(N, 40, "R2");
      push_item(500, 41, "R2");
      push_item((1 << AW) - 1, 42, "R2");
      idle(6);
      // R6: back-to-back stream with mixed amounts
      for (int i = 0; i < 20; i++)
         push_item((i * 53 + 7) % (1 << AW), 60 + i, "R6");
      // R4: gapped items
      for (int i = 0; i < 6; i++) begin
         push_item((i * 91 + 13) % N, 90 + i, "R4");
         idle(i % 3 + 1);
      end
      idle(12);
      check(exp_q.size() == 0, "R4", "items left in flight", exp_q.size(), 0);
      check(out_vld === 1'b0, "R4", "out_vld idle at end", int'(out_vld), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule